// File: doc/BRIEF.md
# DRAM Refresh Request Timer

This block decides when the DRAM must be refreshed and tells a memory controller about it. A programmable 8-bit interval value sets the spacing between refreshes, counted in CPU clocks: the value times sixteen, plus sixteen. Programming the value zero turns refresh generation off. Each refresh that is due raises a request to the controller. The controller retires requests one at a time with an acknowledge.

Two policies handle refreshes that fall due while earlier ones are still waiting. Without burst, a waiting request absorbs any later expiry, so at most one refresh is ever owed. With burst enabled, missed refreshes are saved up to a ceiling of four. The controller can then service them back to back, and the owed count is shown on an output.

When the system is suspended, a select input chooses between two behaviours:
- **CAS-before-RAS refresh.** The block keeps issuing refreshes, timed either from single-cycle pulses of a slow suspend clock or from the normal interval timer.
- **Self-refresh.** The block hands the DRAM over by holding a self-refresh level. It drops any owed refreshes.

Leaving suspend releases the self-refresh level and restarts the interval from zero. Any change of the configuration inputs also restarts the interval. The block does not sequence DRAM commands itself.

Top module: `refresh_timer`

## Requirements
- R1: After reset, `ref_req`, `ref_pending` and `self_ref_req` are all 0.
- R2: The refresh period is `cfg_interval`×16+16 clock cycles. The first request after the counter restarts becomes visible `cfg_interval`×16+17 cycles after the configuration is applied. Later requests follow once every period.
- R3: While `cfg_interval` is 0, no refresh event of any kind is produced, whether from the timer or from `slow_tick`.
- R4: With `cfg_burst_en`=0, `ref_pending` never exceeds 1. An expiry while a request is waiting does not add a second one. Clearing `cfg_burst_en` while more are owed reduces the count to 1 on the next cycle.
- R5: With `cfg_burst_en`=1, each expiry adds one to `ref_pending`, saturating at 4.
- R6: `ref_req` is high exactly when `ref_pending` is nonzero. Each cycle with `ref_ack`=1 while `ref_req` is high lowers the count by one on the next cycle.
- R7: A change on any of `cfg_interval`, `cfg_burst_en`, `cfg_self_sel` or `cfg_normal_timer` restarts the interval count from zero on the next cycle.
- R8: With `suspend`=1, `cfg_self_sel`=0 and `cfg_normal_timer`=0, each cycle with `slow_tick`=1 adds one refresh event. Expiries of the interval timer are ignored.
- R9: With `suspend`=1, `cfg_self_sel`=0 and `cfg_normal_timer`=1, refresh events come from the interval timer as in normal operation.
- R10: With `suspend`=1 and `cfg_self_sel`=1, `self_ref_req` is 1 from the next cycle. `ref_pending` is cleared, and no request is raised, including on a `slow_tick`.
- R11: After `suspend` falls, `self_ref_req` is 0 on the next cycle and the interval count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_interval | input | 8 | Interval value; period = value×16+16 clocks, 0 disables |
| cfg_burst_en | input | 1 | 1 = save up missed refreshes (up to 4) |
| cfg_self_sel | input | 1 | Suspend policy: 1 = self-refresh, 0 = CAS-before-RAS |
| cfg_normal_timer | input | 1 | In suspend CAS-before-RAS: 1 = interval timer, 0 = slow tick |
| suspend | input | 1 | System suspend indication |
| slow_tick | input | 1 | One-cycle pulse from the slow suspend clock |
| ref_ack | input | 1 | Controller acknowledge, retires one refresh |
| ref_req | output | 1 | Refresh request to the controller |
| ref_pending | output | 3 | Number of refreshes owed |
| self_ref_req | output | 1 | Self-refresh entry level (low = exit) |

## Verification
A counter that restarts at the wrong moment, or compares against a period that is off by one, shows up as a first request shifted from its expected cycle. It appears within one period of any configuration change or suspend exit, so the bench measures that cycle exactly. A wrong owed count is visible directly on `ref_pending`, one cycle after the expiry, acknowledge or slow tick that produced it. A wrong mode decode shows as a request raised during self-refresh, a timer expiry counted during slow-tick suspend, or a `self_ref_req` level one cycle late.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    localparam int unsigned IVL_W = 8;

    typedef struct packed {
        logic [IVL_W-1:0] interval;
        logic             burst;
        logic             self_sel;
        logic             normal_timer;
    } ref_cfg_t;

    typedef enum logic [1:0] {
        MODE_RUN       = 2'd0,
        MODE_SUSP_CBR  = 2'd1,
        MODE_SUSP_SELF = 2'd2
    } ref_mode_e;

endpackage

// File: rtl/refresh_interval_ctr.sv
module refresh_interval_ctr
    import refresh_pkg::*;
#(
    parameter int unsigned SHIFT = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  ref_cfg_t cfg_i,
    input  logic     restart_i,
    output logic     tick_o
);
    localparam int unsigned CNT_W = IVL_W + SHIFT;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        ref_cfg_t         cfg;
    } ctr_state_t;

    ctr_state_t s_d, s_q;
    logic [CNT_W-1:0] last_count;
    logic             changed;
    logic             enabled;

    always_comb begin
        s_d        = s_q;
        s_d.cfg    = cfg_i;
        last_count = {cfg_i.interval, {SHIFT{1'b1}}};
        changed    = (cfg_i != s_q.cfg);
        enabled    = (cfg_i.interval != '0);
        tick_o     = 1'b0;
        if (changed || restart_i || !enabled) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == last_count) begin
            s_d.cnt = '0;
            tick_o  = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/refresh_mode_ctl.sv
module refresh_mode_ctl
    import refresh_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      suspend_i,
    input  logic      self_sel_i,
    output ref_mode_e mode_o,
    output logic      leave_o,
    output logic      self_ref_o
);
    typedef struct packed {
        logic susp;
        logic self_ref;
    } mode_state_t;

    mode_state_t s_d, s_q;

    always_comb begin
        s_d.susp     = suspend_i;
        s_d.self_ref = suspend_i && self_sel_i;
        leave_o      = s_q.susp && !suspend_i;
        if (!suspend_i) begin
            mode_o = MODE_RUN;
        end else if (self_sel_i) begin
            mode_o = MODE_SUSP_SELF;
        end else begin
            mode_o = MODE_SUSP_CBR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign self_ref_o = s_q.self_ref;

endmodule

// File: rtl/refresh_pending_q.sv
module refresh_pending_q #(
    parameter int unsigned BURST_MAX = 4,
    localparam int unsigned CW = $clog2(BURST_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          event_i,
    input  logic          clear_i,
    input  logic          burst_i,
    input  logic          ack_i,
    output logic [CW-1:0] pending_o
);
    localparam logic [CW:0] LIM_BURST  = (CW+1)'(BURST_MAX);
    localparam logic [CW:0] LIM_SINGLE = (CW+1)'(1);

    typedef struct packed {
        logic [CW-1:0] pend;
    } pend_state_t;

    pend_state_t s_d, s_q;
    logic [CW:0] sum;
    logic [CW:0] limit;
    logic        dec;

    always_comb begin
        dec   = ack_i && (s_q.pend != '0);
        sum   = {1'b0, s_q.pend} + {{CW{1'b0}}, event_i} - {{CW{1'b0}}, dec};
        limit = burst_i ? LIM_BURST : LIM_SINGLE;
        if (clear_i) begin
            s_d.pend = '0;
        end else if (sum > limit) begin
            s_d.pend = limit[CW-1:0];
        end else begin
            s_d.pend = sum[CW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pending_o = s_q.pend;

endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
    import refresh_pkg::*;
#(
    parameter int unsigned SHIFT     = 4,
    parameter int unsigned BURST_MAX = 4,
    localparam int unsigned CW = $clog2(BURST_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IVL_W-1:0] cfg_interval,
    input  logic             cfg_burst_en,
    input  logic             cfg_self_sel,
    input  logic             cfg_normal_timer,
    input  logic             suspend,
    input  logic             slow_tick,
    input  logic             ref_ack,
    output logic             ref_req,
    output logic [CW-1:0]    ref_pending,
    output logic             self_ref_req
);
    ref_cfg_t  cfg;
    ref_mode_e mode;
    logic      leave;
    logic      tick;
    logic      ref_event;
    logic      clear;

    always_comb begin
        cfg.interval     = cfg_interval;
        cfg.burst        = cfg_burst_en;
        cfg.self_sel     = cfg_self_sel;
        cfg.normal_timer = cfg_normal_timer;
    end

    refresh_mode_ctl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .suspend_i (suspend),
        .self_sel_i(cfg_self_sel),
        .mode_o    (mode),
        .leave_o   (leave),
        .self_ref_o(self_ref_req)
    );

    refresh_interval_ctr #(.SHIFT(SHIFT)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_i    (cfg),
        .restart_i(leave),
        .tick_o   (tick)
    );

    always_comb begin
        clear     = 1'b0;
        ref_event = 1'b0;
        unique case (mode)
            MODE_RUN:       ref_event = tick;
            MODE_SUSP_CBR:  ref_event = cfg_normal_timer ? tick
                                      : (slow_tick && (cfg_interval != '0));
            MODE_SUSP_SELF: clear = 1'b1;
            default:        clear = 1'b1;
        endcase
    end

    refresh_pending_q #(.BURST_MAX(BURST_MAX)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .event_i  (ref_event),
        .clear_i  (clear),
        .burst_i  (cfg_burst_en),
        .ack_i    (ref_ack),
        .pending_o(ref_pending)
    );

    assign ref_req = (ref_pending != '0);

endmodule

// File: rtl/refresh_timer_chk.sv
module refresh_timer_chk
    import refresh_pkg::*;
#(
    parameter int unsigned BURST_MAX = 4,
    localparam int unsigned CW = $clog2(BURST_MAX + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IVL_W-1:0] cfg_interval,
    input logic             cfg_burst_en,
    input logic             cfg_self_sel,
    input logic             suspend,
    input logic             ref_ack,
    input logic             ref_req,
    input logic [CW-1:0]    ref_pending,
    input logic             self_ref_req
);
    assert_burst_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pending <= CW'(BURST_MAX));

    assert_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_burst_en |=> ref_pending <= CW'(1));

    assert_ack_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_ack) |=> ref_pending <= $past(ref_pending));

    assert_zero_disable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_interval == '0) |=> ref_pending <= $past(ref_pending));

    assert_self_enter_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (suspend && cfg_self_sel) |=> (self_ref_req && !ref_req));

    assert_self_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !suspend |=> !self_ref_req);

endmodule

bind refresh_timer refresh_timer_chk #(.BURST_MAX(BURST_MAX)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_interval(cfg_interval),
    .cfg_burst_en(cfg_burst_en),
    .cfg_self_sel(cfg_self_sel),
    .suspend     (suspend),
    .ref_ack     (ref_ack),
    .ref_req     (ref_req),
    .ref_pending (ref_pending),
    .self_ref_req(self_ref_req)
);

// File: tb/tb_refresh_timer.sv
`timescale 1ns/1ps
module tb_refresh_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_interval = '0;
    logic       cfg_burst_en = 1'b0;
    logic       cfg_self_sel = 1'b0;
    logic       cfg_normal_timer = 1'b0;
    logic       suspend = 1'b0;
    logic       slow_tick = 1'b0;
    logic       ref_ack = 1'b0;
    logic       ref_req;
    logic [2:0] ref_pending;
    logic       self_ref_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    refresh_timer dut (
        .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval),
        .cfg_burst_en(cfg_burst_en), .cfg_self_sel(cfg_self_sel),
        .cfg_normal_timer(cfg_normal_timer), .suspend(suspend),
        .slow_tick(slow_tick), .ref_ack(ref_ack), .ref_req(ref_req),
        .ref_pending(ref_pending), .self_ref_req(self_ref_req)
    );

    typedef struct packed {
        logic [7:0] ivl;
        logic       burst;
        logic [3:0] nper;
        logic [2:0] exp;
    } vec_t;

    // R4 / R5: owed count after a number of periods with no acknowledge
    localparam vec_t VECS [6] = '{
        '{ivl: 8'd1, burst: 1'b1, nper: 4'd3, exp: 3'd3},
        '{ivl: 8'd1, burst: 1'b1, nper: 4'd7, exp: 3'd4},
        '{ivl: 8'd1, burst: 1'b0, nper: 4'd3, exp: 3'd1},
        '{ivl: 8'd2, burst: 1'b1, nper: 4'd2, exp: 3'd2},
        '{ivl: 8'd3, burst: 1'b0, nper: 4'd1, exp: 3'd1},
        '{ivl: 8'd1, burst: 1'b1, nper: 4'd1, exp: 3'd1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drain();
        cfg_interval = 8'd0;
        ref_ack = 1'b1;
        repeat (8) @(negedge clk);
        ref_ack = 1'b0;
    endtask

    task automatic wait_req(output int n);
        n = 0;
        while (!ref_req && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(ref_req == 1'b0, "R1 ref_req", int'(ref_req), 0);
        check(ref_pending == 3'd0, "R1 ref_pending", int'(ref_pending), 0);
        check(self_ref_req == 1'b0, "R1 self_ref_req", int'(self_ref_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 / R4: table walk
        for (int i = 0; i < 6; i++) begin
            int p;
            drain();
            p = int'(VECS[i].ivl) * 16 + 16;
            cfg_burst_en = VECS[i].burst;
            cfg_interval = VECS[i].ivl;
            repeat (int'(VECS[i].nper) * p + 5) @(negedge clk);
            check(ref_pending == VECS[i].exp, VECS[i].burst ? "R5 burst count" : "R4 single count",
                  int'(ref_pending), int'(VECS[i].exp));
        end

        // R6: one acknowledge retires one refresh
        drain();
        cfg_burst_en = 1'b1;
        cfg_interval = 8'd1;
        repeat (3 * 32 + 5) @(negedge clk);
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0;
        check(ref_pending == 3'd2, "R6 ack drain", int'(ref_pending), 2);
        check(ref_req == 1'b1, "R6 req level", int'(ref_req), 1);

        // R4: clearing burst clamps the count to one
        cfg_burst_en = 1'b0;
        @(negedge clk);
        check(ref_pending == 3'd1, "R4 clamp", int'(ref_pending), 1);

        // R2: exact first-request cycle for two intervals
        drain();
        cfg_interval = 8'd2;
        wait_req(n);
        check(n == 49, "R2 period 48", n, 49);
        drain();
        cfg_interval = 8'd3;
        wait_req(n);
        check(n == 65, "R2 period 64", n, 65);

        // R7: a configuration change restarts the count
        drain();
        cfg_interval = 8'd2;
        repeat (30) @(negedge clk);
        cfg_burst_en = 1'b1;
        wait_req(n);
        check(n == 49, "R7 restart on change", n, 49);

        // R3: zero interval disables, including the slow tick in suspend
        drain();
        cfg_burst_en = 1'b1;
        repeat (300) @(negedge clk);
        check(ref_pending == 3'd0, "R3 zero interval", int'(ref_pending), 0);
        suspend = 1'b1;
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
        @(negedge clk);
        check(ref_pending == 3'd0, "R3 zero with slow tick", int'(ref_pending), 0);

        // R8: suspend CAS-before-RAS on the slow tick, timer ignored
        cfg_interval = 8'd1;
        repeat (100) @(negedge clk);
        check(ref_pending == 3'd0, "R8 timer ignored", int'(ref_pending), 0);
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
        check(ref_pending == 3'd1, "R8 slow tick", int'(ref_pending), 1);

        // R9: suspend CAS-before-RAS on the normal timer
        cfg_normal_timer = 1'b1;
        repeat (35) @(negedge clk);
        check(ref_pending == 3'd2, "R9 normal timer", int'(ref_pending), 2);

        // R10: self-refresh entry
        cfg_self_sel = 1'b1;
        @(negedge clk);
        check(self_ref_req == 1'b1, "R10 self level", int'(self_ref_req), 1);
        check(ref_pending == 3'd0, "R10 cleared", int'(ref_pending), 0);
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
        repeat (40) @(negedge clk);
        check(ref_req == 1'b0, "R10 no request", int'(ref_req), 0);

        // R11: leaving suspend releases self-refresh and restarts the count
        suspend = 1'b0;
        @(negedge clk);
        check(self_ref_req == 1'b0, "R11 self release", int'(self_ref_req), 0);
        wait_req(n);
        check(n == 32, "R11 restart after exit", n, 32);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule